// File: doc/BRIEF.md
# Toeplitz flow hash engine

This block hashes one receive flow per request with the Toeplitz algorithm and turns the hash into a bucket index for a flow table. A 320-bit secret key is loaded one byte at a time through a small write port. Before hashing, the key is moved five bit positions toward its most significant end. A flow is offered as a full IPv6-width 5-tuple with a valid/ready handshake. The block builds a 320-bit input block from the tuple and runs it through the hash, most significant bit first.

When the hash completes, the block asserts a one-cycle result strobe. The raw 32-bit hash and the table index are presented together with that strobe. The index is the hash shifted right by a parameterised amount and masked to a power-of-two table size. A parameter sets how many input bits are consumed per clock: one bit per cycle for the smallest area, or a byte per cycle for lower latency. While a hash is running, both the tuple port and the key port report not-ready.

Top module: `toeplitz_flow_hash`

## Requirements
- R1: A key byte write is accepted on a clock edge where key_wr_valid and key_wr_ready are both high. Address 0 holds key bits 319:312, the most significant byte, and address 39 holds key bits 7:0.
- R2: The hash uses the key shifted left by 5 bit positions, with zeros filling the low 5 bits. With only input bit 0 set, the hash equals original key bits 314:283.
- R3: Input bit i counts from 0 at the most significant bit of the block. For every set input bit i, the 32 shifted-key bits [319-i : 288-i] are XORed into the hash, and key positions below bit 0 read as zero.
- R4: The 320-bit input block is laid out as follows, from its most significant end: the 128-bit source address, the 128-bit destination address, the 16-bit destination port, the 16-bit source port, 24 zero bits, and the 8-bit L4 protocol.
- R5: out_index equals (out_hash >> 12) & (TABLE_ENTRIES-1), with TABLE_ENTRIES = 1024 by default.
- R6: The hash accumulator is cleared when each request is accepted. A request offered in the cycle of the previous result is accepted at once, and its result does not depend on earlier requests.
- R7: out_valid is a pulse of exactly one cycle. out_hash and out_index are valid in that cycle, and they hold while no new request arrives.
- R8: in_ready is low while a hash runs. A tuple offered then is ignored and produces no result.
- R9: key_wr_ready is low while a hash runs. A key write offered then has no effect, and the key in use stays unchanged.
- R10: An all-zero tuple yields a hash of 0 for any key.
- R11: With BITS_PER_CYCLE = 8 (the default), out_valid rises 40 cycles after the accepting edge. In general the latency is 320 / BITS_PER_CYCLE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr_valid | input | 1 | Key byte write request |
| key_wr_ready | output | 1 | Key port can accept a write (low while hashing) |
| key_wr_addr | input | 6 | Key byte address, 0 = most significant |
| key_wr_data | input | 8 | Key byte value |
| in_valid | input | 1 | Tuple request |
| in_ready | output | 1 | Tuple port can accept (low while hashing) |
| src_addr | input | 128 | Source address |
| dst_addr | input | 128 | Destination address |
| src_port | input | 16 | L4 source port |
| dst_port | input | 16 | L4 destination port |
| l4_proto | input | 8 | L4 protocol number |
| out_valid | output | 1 | One-cycle result strobe |
| out_hash | output | 32 | Raw Toeplitz hash |
| out_index | output | 10 | Table index derived from the hash |

## Verification
The embedded properties make three assumptions about the inputs. Key addresses stay below 40. Reset is applied before any traffic. in_valid is low in a result cycle whenever the property on result stability applies. The stimulus keeps within these limits in three ways: it always writes addresses 0 to 39, it drives all inputs on the falling clock edge, and it offers requests only when ready was seen high, except in the deliberate busy-window probes. In those probes, tuples and key writes are offered while the engine is running, and the results are checked against the old key. The expected hashes come from a plain bit-by-bit model of the shifted-key window, which is separate from the shifting-register form used in the design.

// File: rtl/toeplitz_pkg.sv
package toeplitz_pkg;

   typedef enum logic {
      TH_IDLE = 1'b0,
      TH_RUN  = 1'b1
   } th_state_e;

   localparam int unsigned TH_PROTO_WORD_W = 32;

endpackage

// File: rtl/th_key_store.sv
module th_key_store #(
   parameter int unsigned KEY_BYTES = 40,
   localparam int unsigned AW       = $clog2(KEY_BYTES),
   localparam int unsigned KEY_BITS = KEY_BYTES * 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_fire,
   input  logic [AW-1:0]       wr_addr,
   input  logic [7:0]          wr_data,
   output logic [KEY_BITS-1:0] key_vec
);

   if (KEY_BYTES < 5) begin : g_bad_key
      $error("th_key_store: KEY_BYTES too small");
   end

   for (genvar g = 0; g < KEY_BYTES; g++) begin : g_byte
      localparam logic [AW-1:0] SLOT = AW'(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            key_vec[(KEY_BYTES-1-g)*8 +: 8] <= '0;
         else if (wr_fire && (wr_addr == SLOT))
            key_vec[(KEY_BYTES-1-g)*8 +: 8] <= wr_data;
      end
   end

endmodule

// File: rtl/th_core.sv
module th_core
   import toeplitz_pkg::*;
#(
   parameter int unsigned DATA_BITS = 320,
   parameter int unsigned KEY_BITS  = 320,
   parameter int unsigned HASH_W    = 32,
   parameter int unsigned STEP      = 8,
   parameter int unsigned PRESHIFT  = 5,
   localparam int unsigned CYC      = DATA_BITS / STEP,
   localparam int unsigned CW       = $clog2(CYC + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [DATA_BITS-1:0] data_in,
   input  logic [KEY_BITS-1:0]  key_in,
   output logic                 busy,
   output logic                 done,
   output logic [HASH_W-1:0]    hash
);

   if ((DATA_BITS % STEP) != 0) begin : g_bad_step
      $error("th_core: DATA_BITS must be a multiple of STEP");
   end
   if (KEY_BITS < HASH_W + STEP - 1) begin : g_bad_key
      $error("th_core: key too short for the step window");
   end
   if (PRESHIFT >= KEY_BITS) begin : g_bad_shift
      $error("th_core: PRESHIFT out of range");
   end

   th_state_e              state;
   logic [CW-1:0]          cnt;
   logic [DATA_BITS-1:0]   dreg;
   logic [KEY_BITS-1:0]    sreg;
   logic [HASH_W-1:0]      acc;
   logic [HASH_W-1:0]      nxt;

   // Fold STEP input bits into the accumulator per cycle.
   if (STEP == 1) begin : g_serial
      always_comb begin
         nxt = acc;
         if (dreg[DATA_BITS-1])
            nxt = acc ^ sreg[KEY_BITS-1 -: HASH_W];
      end
   end else begin : g_parallel
      always_comb begin
         nxt = acc;
         for (int b = 0; b < STEP; b++) begin
            if (dreg[DATA_BITS-1-b])
               nxt = nxt ^ sreg[KEY_BITS-1-b -: HASH_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TH_IDLE;
         cnt   <= '0;
         dreg  <= '0;
         sreg  <= '0;
         acc   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            TH_IDLE: begin
               if (start) begin
                  dreg  <= data_in;
                  sreg  <= key_in << PRESHIFT;
                  acc   <= '0;
                  cnt   <= CW'(CYC);
                  state <= TH_RUN;
               end
            end
            TH_RUN: begin
               acc  <= nxt;
               dreg <= dreg << STEP;
               sreg <= sreg << STEP;
               cnt  <= cnt - CW'(1);
               if (cnt == CW'(1)) begin
                  state <= TH_IDLE;
                  done  <= 1'b1;
               end
            end
            default: state <= TH_IDLE;
         endcase
      end
   end

   assign busy = (state == TH_RUN);
   assign hash = acc;

   // R6
   clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (acc == '0) && busy);

   // R8
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   // R11
   done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy) && !busy);

endmodule

// File: rtl/th_index.sv
module th_index #(
   parameter int unsigned HASH_W  = 32,
   parameter int unsigned SHIFT   = 12,
   parameter int unsigned ENTRIES = 1024,
   localparam int unsigned IW     = $clog2(ENTRIES)
) (
   input  logic [HASH_W-1:0] hash,
   output logic [IW-1:0]     index
);

   if ((ENTRIES < 2) || ((ENTRIES & (ENTRIES - 1)) != 0)) begin : g_bad_entries
      $error("th_index: ENTRIES must be a power of two");
   end
   if (SHIFT + IW > HASH_W) begin : g_bad_shift
      $error("th_index: index field exceeds hash width");
   end

   logic [HASH_W-1:0] shifted;
   assign shifted = hash >> SHIFT;
   assign index   = shifted[IW-1:0];

endmodule

// File: rtl/toeplitz_flow_hash.sv
module toeplitz_flow_hash
   import toeplitz_pkg::*;
#(
   parameter int unsigned KEY_BYTES      = 40,
   parameter int unsigned ADDR_W         = 128,
   parameter int unsigned PORT_W         = 16,
   parameter int unsigned PROTO_W        = 8,
   parameter int unsigned HASH_W         = 32,
   parameter int unsigned KEY_PRESHIFT   = 5,
   parameter int unsigned IDX_SHIFT      = 12,
   parameter int unsigned TABLE_ENTRIES  = 1024,
   parameter int unsigned BITS_PER_CYCLE = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             key_wr_valid,
   output logic                             key_wr_ready,
   input  logic [$clog2(KEY_BYTES)-1:0]     key_wr_addr,
   input  logic [7:0]                       key_wr_data,
   input  logic                             in_valid,
   output logic                             in_ready,
   input  logic [ADDR_W-1:0]                src_addr,
   input  logic [ADDR_W-1:0]                dst_addr,
   input  logic [PORT_W-1:0]                src_port,
   input  logic [PORT_W-1:0]                dst_port,
   input  logic [PROTO_W-1:0]               l4_proto,
   output logic                             out_valid,
   output logic [HASH_W-1:0]                out_hash,
   output logic [$clog2(TABLE_ENTRIES)-1:0] out_index
);

   localparam int unsigned KEY_BITS  = KEY_BYTES * 8;
   localparam int unsigned DATA_BITS = 2 * ADDR_W + 2 * PORT_W + TH_PROTO_WORD_W;
   localparam int unsigned PAD_W     = TH_PROTO_WORD_W - PROTO_W;

   if (PROTO_W >= TH_PROTO_WORD_W) begin : g_bad_proto
      $error("toeplitz_flow_hash: protocol field too wide");
   end
   if (DATA_BITS > KEY_BITS) begin : g_bad_block
      $error("toeplitz_flow_hash: input block longer than key");
   end

   logic                 busy;
   logic                 start;
   logic                 key_fire;
   logic [KEY_BITS-1:0]  key_vec;
   logic [DATA_BITS-1:0] block;

   assign start        = in_valid && !busy;
   assign key_fire     = key_wr_valid && !busy;
   assign in_ready     = !busy;
   assign key_wr_ready = !busy;

   assign block = {src_addr, dst_addr, dst_port, src_port, {PAD_W{1'b0}}, l4_proto};

   th_key_store #(
      .KEY_BYTES (KEY_BYTES)
   ) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (key_fire),
      .wr_addr (key_wr_addr),
      .wr_data (key_wr_data),
      .key_vec (key_vec)
   );

   th_core #(
      .DATA_BITS (DATA_BITS),
      .KEY_BITS  (KEY_BITS),
      .HASH_W    (HASH_W),
      .STEP      (BITS_PER_CYCLE),
      .PRESHIFT  (KEY_PRESHIFT)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .data_in (block),
      .key_in  (key_vec),
      .busy    (busy),
      .done    (out_valid),
      .hash    (out_hash)
   );

   th_index #(
      .HASH_W  (HASH_W),
      .SHIFT   (IDX_SHIFT),
      .ENTRIES (TABLE_ENTRIES)
   ) u_index (
      .hash  (out_hash),
      .index (out_index)
   );

   // R9
   key_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(key_vec));

   // R7
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !in_valid) |=> $stable(out_hash));

   // R8
   ready_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !in_ready && !key_wr_ready);

endmodule

// File: tb/sim_toeplitz_flow_hash.sv
module sim_toeplitz_flow_hash;

   localparam int LAT = 40;

   typedef struct packed {
      logic [31:0] h;
      logic [9:0]  ix;
      logic [31:0] cyc;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         key_wr_valid = 1'b0;
   logic         key_wr_ready;
   logic [5:0]   key_wr_addr = '0;
   logic [7:0]   key_wr_data = '0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] src_addr = '0;
   logic [127:0] dst_addr = '0;
   logic [15:0]  src_port = '0;
   logic [15:0]  dst_port = '0;
   logic [7:0]   l4_proto = '0;
   logic         out_valid;
   logic [31:0]  out_hash;
   logic [9:0]   out_index;

   int   checks = 0;
   int   errors = 0;
   int   ncyc   = 0;
   int   nres   = 0;
   int   nsent  = 0;
   exp_t sb[$];
   logic [319:0] key_model = '0;

   always #4 clk = ~clk;

   toeplitz_flow_hash u0 (
      .clk, .rst_n, .key_wr_valid, .key_wr_ready, .key_wr_addr, .key_wr_data,
      .in_valid, .in_ready, .src_addr, .dst_addr, .src_port, .dst_port,
      .l4_proto, .out_valid, .out_hash, .out_index
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model(input logic [319:0] k, input logic [319:0] d);
      logic [351:0] ext;
      logic [31:0]  h;
      ext = {k << 5, 32'd0};
      h = '0;
      for (int i = 0; i < 320; i++)
         if (d[319-i]) h = h ^ ext[351-i -: 32];
      return h;
   endfunction

   // R1: write one key byte through the handshake
   task automatic wr_key_byte(input logic [5:0] a, input logic [7:0] v);
      @(negedge clk);
      while (!key_wr_ready) @(negedge clk);
      key_wr_valid = 1'b1;
      key_wr_addr  = a;
      key_wr_data  = v;
      key_model[(39-a)*8 +: 8] = v;
      @(negedge clk);
      key_wr_valid = 1'b0;
   endtask

   task automatic load_key(input logic [319:0] k);
      for (int g = 0; g < 40; g++) wr_key_byte(6'(g), k[(39-g)*8 +: 8]);
   endtask

   // Driver: offers a tuple and pushes the expected result
   task automatic send(input logic [127:0] s, input logic [127:0] d,
                       input logic [15:0] sp, input logic [15:0] dp,
                       input logic [7:0] pr);
      logic [319:0] blk;
      exp_t e;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      src_addr = s; dst_addr = d; src_port = sp; dst_port = dp; l4_proto = pr;
      #1;
      blk   = {s, d, dp, sp, 24'd0, pr};
      e.h   = model(key_model, blk);
      e.ix  = 10'((e.h >> 12) & 32'd1023);
      e.cyc = 32'(ncyc + LAT + 1);
      sb.push_back(e);
      nsent++;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      for (int t = 0; t < 400 && sb.size() != 0; t++) @(negedge clk);
      @(negedge clk);
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      ncyc = ncyc + 1;
      if (rst_n && out_valid) begin
         nres++;
         if (sb.size() == 0) begin
            chk(1'b0, "R8 unexpected result", 64'(out_hash), 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(out_hash == e.h, "R3 hash", 64'(out_hash), 64'(e.h));
            chk(out_index == e.ix, "R5 index", 64'(out_index), 64'(e.ix));
            chk(32'(ncyc) == e.cyc, "R11 latency", 64'(ncyc), 64'(e.cyc));
         end
      end
   end

   initial begin : watchdog
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [319:0] k1;
      logic [319:0] k2;
      logic [31:0]  held;
      for (int g = 0; g < 10; g++) k1[g*32 +: 32] = $urandom;
      for (int g = 0; g < 10; g++) k2[g*32 +: 32] = $urandom;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      chk(out_valid == 1'b0, "R7 reset out_valid", 64'(out_valid), 64'd0);
      chk(in_ready == 1'b1, "R8 reset in_ready", 64'(in_ready), 64'd1);
      chk(key_wr_ready == 1'b1, "R9 reset key_wr_ready", 64'(key_wr_ready), 64'd1);

      load_key(k1);   // R1

      // R10: all-zero tuple gives zero hash
      chk(model(key_model, '0) == 32'd0, "R10 model zero", 64'(model(key_model, '0)), 64'd0);
      send('0, '0, '0, '0, '0);
      drain();
      chk(out_hash == 32'd0, "R10 zero tuple hash", 64'(out_hash), 64'd0);

      // R2: only the first input bit set selects original key bits 314:283
      send({1'b1, 127'd0}, '0, '0, '0, '0);
      drain();
      chk(out_hash == k1[314:283], "R2 preshift window", 64'(out_hash), 64'(k1[314:283]));
      // R7: result holds while idle
      held = out_hash;
      repeat (5) @(negedge clk);
      chk(out_hash == held, "R7 hold", 64'(out_hash), 64'(held));

      // R4: single fields exercise the block layout
      send('0, '0, '0, '0, 8'h01);
      send('0, '0, 16'h8000, '0, '0);
      send('0, '0, '0, 16'h0001, '0);
      send('0, {127'd0, 1'b1}, '0, '0, '0);
      send(128'h1, '0, '0, '0, 8'h06);

      // R6: back-to-back random tuples
      for (int n = 0; n < 20; n++)
         send({$urandom, $urandom, $urandom, $urandom},
              {$urandom, $urandom, $urandom, $urandom},
              16'($urandom), 16'($urandom), 8'($urandom));
      drain();

      // R8 / R9: probes during a running hash
      send({4{32'hA5A5_1234}}, {4{32'h0F0F_9876}}, 16'd443, 16'd5000, 8'd17);
      @(negedge clk);
      chk(in_ready == 1'b0, "R8 in_ready busy", 64'(in_ready), 64'd0);
      chk(key_wr_ready == 1'b0, "R9 key_wr_ready busy", 64'(key_wr_ready), 64'd0);
      in_valid = 1'b1;
      src_addr = '1;
      key_wr_valid = 1'b1;
      key_wr_addr  = 6'd0;
      key_wr_data  = ~key_model[319:312];
      repeat (4) @(negedge clk);
      in_valid = 1'b0;
      key_wr_valid = 1'b0;
      drain();
      chk(nres == nsent, "R8 result count", 64'(nres), 64'(nsent));
      // key must be unchanged: hash again with old key in the model
      send({1'b1, 127'd0}, '0, '0, '0, '0);
      drain();
      chk(out_hash == k1[314:283], "R9 key unchanged", 64'(out_hash), 64'(k1[314:283]));

      // R1: reload with a new key, results follow it
      load_key(k2);
      send({1'b1, 127'd0}, '0, '0, '0, '0);
      drain();
      chk(out_hash == k2[314:283], "R1 new key", 64'(out_hash), 64'(k2[314:283]));
      for (int n = 0; n < 6; n++)
         send({$urandom, $urandom, $urandom, $urandom},
              {$urandom, $urandom, $urandom, $urandom},
              16'($urandom), 16'($urandom), 8'($urandom));
      drain();
      chk(sb.size() == 0, "R6 scoreboard empty", 64'(sb.size()), 64'd0);
      chk(nres == nsent, "R7 one result per request", 64'(nres), 64'(nsent));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule